// File: doc/BRIEF.md
# Fast-to-Slow Configuration Transfer

This block moves a bundle of power-related settings from a fast bus clock domain into a slow always-on clock domain. The settings are five low-power control flags, a wakeup enable mask and a reset enable mask. Register decode produces these values in the fast domain, but only the slow domain uses them. They do not flow across on their own. Software writes a one to a sync trigger. The block then takes a snapshot of the current fast-domain settings and holds it. The transfer request crosses as a toggle through a flip-flop synchronizer. The slow side loads the held snapshot when the toggle change arrives. An acknowledge toggle then crosses back the same way.

A busy bit is set when software writes the trigger and clears itself once the acknowledge returns. Software polls this bit. When it reads zero, the slow domain holds the new settings. The slow-domain low-power USB clock enable is gated by the main power-domain keep-on flag. A cleared keep-on flag always forces that enable off.

Top module: `cfgx_sync_top`

## Requirements
- R1: After reset, `sync_busy_o` is 0. The slow outputs read: core, IO and USB low-power clock enables 0, USB active clock enable 1, main keep-on 1, both masks all zeros.
- R2: The slow outputs change only while a transfer is in flight. Fast-domain setting changes with no trigger never reach them.
- R3: A trigger write (`sync_wr_i` high at a fast edge while `sync_busy_o` is 0) makes `sync_busy_o` read 1 after that same edge.
- R4: `sync_busy_o` returns to 0 within 64 fast cycles of the accepting edge. From then on the slow outputs show the settings present at that edge.
- R5: `slow_usb_lp_o` is 0 whenever `slow_main_keep_o` is 0, whatever the captured USB low-power setting is.
- R6: Fast-domain settings changed after the accepting edge do not affect the transferred values. The snapshot register stays stable while busy.
- R7: A trigger write while `sync_busy_o` is 1 has no effect. No second transfer occurs, and the busy bit stays 0 once the first transfer completes.
- R8: Each transfer is acknowledged: the slow side toggles its acknowledge exactly once per request toggle it sees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast bus clock |
| rst_fast_ni | input | 1 | Fast-domain synchronous active-low reset |
| clk_slow_i | input | 1 | Slow always-on clock |
| rst_slow_ni | input | 1 | Slow-domain synchronous active-low reset |
| core_lp_i | input | 1 | Core clock enable in low power (fast domain) |
| io_lp_i | input | 1 | IO clock enable in low power (fast domain) |
| usb_lp_i | input | 1 | USB clock enable in low power (fast domain) |
| usb_act_i | input | 1 | USB clock enable when active (fast domain) |
| main_keep_i | input | 1 | Keep main power domain on in low power (fast domain) |
| wake_en_i | input | NUM_WAKE | Wakeup enable mask (fast domain) |
| rst_en_i | input | NUM_RST | Reset request enable mask (fast domain) |
| sync_wr_i | input | 1 | Software write of one to the sync trigger |
| sync_busy_o | output | 1 | Self-clearing sync status bit |
| slow_core_lp_o | output | 1 | Transferred core low-power clock enable |
| slow_io_lp_o | output | 1 | Transferred IO low-power clock enable |
| slow_usb_lp_o | output | 1 | Transferred USB low-power clock enable, gated by keep-on |
| slow_usb_act_o | output | 1 | Transferred USB active clock enable |
| slow_main_keep_o | output | 1 | Transferred main power-domain keep-on |
| slow_wake_en_o | output | NUM_WAKE | Transferred wakeup enable mask |
| slow_rst_en_o | output | NUM_RST | Transferred reset enable mask |

## Verification
The bench builds the block with six wakeup bits, two reset bits and two synchronizer stages. The slow clock period is 37 ns against a 10 ns fast clock. Because the ratio is not an integer, slow edges drift across every phase of the fast cycle. Request and acknowledge crossings therefore take different fast-cycle counts from one transfer to the next. The narrow masks allow distinct patterns, such as all ones, alternating bits and single bits, in each field. Together these make a wrong bit order, a missing gate or a leaked live input show up in a few transfers.

// File: rtl/cfgx_pkg.sv
// Shared types for the configuration transfer block.
// Assumes the control flags sit in the low bits of the flat payload vector.
package cfgx_pkg;

    typedef struct packed {
        logic main_keep;
        logic usb_act;
        logic usb_lp;
        logic io_lp;
        logic core_lp;
    } lp_ctrl_t;

    localparam int CTRL_W = $bits(lp_ctrl_t);

    localparam lp_ctrl_t CTRL_RESET = '{
        main_keep: 1'b1,
        usb_act:   1'b1,
        usb_lp:    1'b0,
        io_lp:     1'b0,
        core_lp:   1'b0
    };

endpackage

// File: rtl/cfgx_sync_flop.sv
// Multi-stage flip-flop synchronizer for a single level or toggle signal.
// Assumes the input changes at most once per several destination cycles.
module cfgx_sync_flop #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfgx_fast_side.sv
// Fast-domain half: snapshots the payload on an accepted trigger, flips the
// request toggle and reports busy until the returned acknowledge matches.
// Assumes ack_sync_i is already synchronized into the fast clock domain.
module cfgx_fast_side #(
    parameter int PW = 8,
    parameter logic [PW-1:0] RESET_VAL = '0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [PW-1:0] payload_i,
    input  logic          sync_wr_i,
    input  logic          ack_sync_i,
    output logic          req_tgl_o,
    output logic [PW-1:0] held_o,
    output logic          busy_o
);

    logic          req_q;
    logic [PW-1:0] held_q;
    logic          accept;

    assign busy_o = req_q ^ ack_sync_i;
    assign accept = sync_wr_i & ~busy_o;

    // Capture the payload and flip the request when a trigger is accepted.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            req_q  <= 1'b0;
            held_q <= RESET_VAL;
        end else if (accept) begin
            req_q  <= ~req_q;
            held_q <= payload_i;
        end
    end

    assign req_tgl_o = req_q;
    assign held_o    = held_q;

endmodule

// File: rtl/cfgx_slow_side.sv
// Slow-domain half: detects a request toggle change, loads the held payload
// and returns the acknowledge toggle.
// Assumes the held payload is stable whenever the request toggle differs
// from the acknowledge toggle.
module cfgx_slow_side #(
    parameter int PW = 8,
    parameter logic [PW-1:0] RESET_VAL = '0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_sync_i,
    input  logic [PW-1:0] held_i,
    output logic          pulse_o,
    output logic          ack_tgl_o,
    output logic [PW-1:0] cfg_o
);

    logic          seen_q;
    logic [PW-1:0] cfg_q;

    assign pulse_o = req_sync_i ^ seen_q;

    // Load the payload and echo the toggle when a new request arrives.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seen_q <= 1'b0;
            cfg_q  <= RESET_VAL;
        end else if (pulse_o) begin
            seen_q <= req_sync_i;
            cfg_q  <= held_i;
        end
    end

    assign ack_tgl_o = seen_q;
    assign cfg_o     = cfg_q;

endmodule

// File: rtl/cfgx_sync_top.sv
// Top of the configuration transfer: packs the settings, wires the fast and
// slow halves through toggle synchronizers and unpacks the slow settings.
// Assumes both resets are synchronous to their own clocks and active low.
module cfgx_sync_top
    import cfgx_pkg::*;
#(
    parameter int NUM_WAKE    = 6,
    parameter int NUM_RST     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_fast_i,
    input  logic                rst_fast_ni,
    input  logic                clk_slow_i,
    input  logic                rst_slow_ni,
    input  logic                core_lp_i,
    input  logic                io_lp_i,
    input  logic                usb_lp_i,
    input  logic                usb_act_i,
    input  logic                main_keep_i,
    input  logic [NUM_WAKE-1:0] wake_en_i,
    input  logic [NUM_RST-1:0]  rst_en_i,
    input  logic                sync_wr_i,
    output logic                sync_busy_o,
    output logic                slow_core_lp_o,
    output logic                slow_io_lp_o,
    output logic                slow_usb_lp_o,
    output logic                slow_usb_act_o,
    output logic                slow_main_keep_o,
    output logic [NUM_WAKE-1:0] slow_wake_en_o,
    output logic [NUM_RST-1:0]  slow_rst_en_o
);

    localparam int PW = CTRL_W + NUM_WAKE + NUM_RST;
    localparam logic [PW-1:0] PAYLOAD_RESET = {{(NUM_RST + NUM_WAKE){1'b0}}, CTRL_RESET};

    lp_ctrl_t      ctrl_in;
    lp_ctrl_t      ctrl_slow;
    logic [PW-1:0] payload;
    logic [PW-1:0] held_q;
    logic [PW-1:0] slow_cfg_q;
    logic          req_tgl;
    logic          req_sync;
    logic          ack_tgl;
    logic          ack_sync;
    logic          slow_pulse;

    // Pack the fast-domain settings into one flat payload.
    always_comb begin
        ctrl_in.core_lp   = core_lp_i;
        ctrl_in.io_lp     = io_lp_i;
        ctrl_in.usb_lp    = usb_lp_i;
        ctrl_in.usb_act   = usb_act_i;
        ctrl_in.main_keep = main_keep_i;
        payload           = {rst_en_i, wake_en_i, ctrl_in};
    end

    cfgx_fast_side #(.PW(PW), .RESET_VAL(PAYLOAD_RESET)) u_fast (
        .clk_i      (clk_fast_i),
        .rst_ni     (rst_fast_ni),
        .payload_i  (payload),
        .sync_wr_i  (sync_wr_i),
        .ack_sync_i (ack_sync),
        .req_tgl_o  (req_tgl),
        .held_o     (held_q),
        .busy_o     (sync_busy_o)
    );

    cfgx_sync_flop #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk_i  (clk_slow_i),
        .rst_ni (rst_slow_ni),
        .d_i    (req_tgl),
        .q_o    (req_sync)
    );

    cfgx_slow_side #(.PW(PW), .RESET_VAL(PAYLOAD_RESET)) u_slow (
        .clk_i      (clk_slow_i),
        .rst_ni     (rst_slow_ni),
        .req_sync_i (req_sync),
        .held_i     (held_q),
        .pulse_o    (slow_pulse),
        .ack_tgl_o  (ack_tgl),
        .cfg_o      (slow_cfg_q)
    );

    cfgx_sync_flop #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk_i  (clk_fast_i),
        .rst_ni (rst_fast_ni),
        .d_i    (ack_tgl),
        .q_o    (ack_sync)
    );

    // Unpack the slow settings and gate the USB low-power enable by keep-on.
    always_comb begin
        ctrl_slow        = lp_ctrl_t'(slow_cfg_q[CTRL_W-1:0]);
        slow_core_lp_o   = ctrl_slow.core_lp;
        slow_io_lp_o     = ctrl_slow.io_lp;
        slow_usb_lp_o    = ctrl_slow.usb_lp & ctrl_slow.main_keep;
        slow_usb_act_o   = ctrl_slow.usb_act;
        slow_main_keep_o = ctrl_slow.main_keep;
        slow_wake_en_o   = slow_cfg_q[CTRL_W +: NUM_WAKE];
        slow_rst_en_o    = slow_cfg_q[CTRL_W + NUM_WAKE +: NUM_RST];
    end

endmodule

// File: rtl/cfgx_sync_chk.sv
// Protocol checker for the configuration transfer, bound into the top.
// Assumes it observes the top's internal handshake signals by name.
module cfgx_sync_chk #(
    parameter int PW = 8
) (
    input logic          clk_fast_i,
    input logic          rst_fast_ni,
    input logic          clk_slow_i,
    input logic          rst_slow_ni,
    input logic          sync_wr_i,
    input logic          busy,
    input logic [PW-1:0] held,
    input logic          slow_pulse,
    input logic          ack_tgl,
    input logic [PW-1:0] slow_cfg,
    input logic          main_keep,
    input logic          usb_lp
);

    AST_BUSY_ON_TRIGGER: assert property (@(posedge clk_fast_i) disable iff (!rst_fast_ni)
        (sync_wr_i && !busy) |=> busy); // R3

    AST_SNAPSHOT_HELD: assert property (@(posedge clk_fast_i) disable iff (!rst_fast_ni)
        ($past(busy) && busy) |-> $stable(held)); // R6

    AST_USB_GATED: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
        !main_keep |-> !usb_lp); // R5

    AST_SLOW_QUIET: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
        !slow_pulse |=> $stable(slow_cfg)); // R2

    AST_ACK_ECHO: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
        slow_pulse |=> (ack_tgl != $past(ack_tgl))); // R8

endmodule

bind cfgx_sync_top cfgx_sync_chk #(.PW(PW)) u_chk (
    .clk_fast_i  (clk_fast_i),
    .rst_fast_ni (rst_fast_ni),
    .clk_slow_i  (clk_slow_i),
    .rst_slow_ni (rst_slow_ni),
    .sync_wr_i   (sync_wr_i),
    .busy        (sync_busy_o),
    .held        (held_q),
    .slow_pulse  (slow_pulse),
    .ack_tgl     (ack_tgl),
    .slow_cfg    (slow_cfg_q),
    .main_keep   (slow_main_keep_o),
    .usb_lp      (slow_usb_lp_o)
);

// File: tb/cfgx_sync_top_bench.sv
`timescale 1ns/100ps
module cfgx_sync_top_bench;

    localparam int NW = 6;
    localparam int NR = 2;
    localparam int VW = 5 + NW + NR;

    logic clk_fast = 1'b0;
    logic clk_slow = 1'b0;
    logic rst_fast_n = 1'b0;
    logic rst_slow_n = 1'b0;
    logic core_lp = 0, io_lp = 0, usb_lp = 0, usb_act = 1, main_keep = 1;
    logic [NW-1:0] wake_en = '0;
    logic [NR-1:0] rst_en = '0;
    logic sync_wr = 1'b0;
    logic busy;
    logic s_core, s_io, s_usb_lp, s_usb_act, s_keep;
    logic [NW-1:0] s_wake;
    logic [NR-1:0] s_rst;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // Reference model state: settings as a flat vector {rst, wake, keep, act, usblp, io, core}.
    logic [VW-1:0] committed;
    logic [VW-1:0] pend_q[$];
    bit            model_pending = 0;

    cfgx_sync_top #(.NUM_WAKE(NW), .NUM_RST(NR), .SYNC_STAGES(2)) u_cfgx_sync_top (
        .clk_fast_i(clk_fast), .rst_fast_ni(rst_fast_n),
        .clk_slow_i(clk_slow), .rst_slow_ni(rst_slow_n),
        .core_lp_i(core_lp), .io_lp_i(io_lp), .usb_lp_i(usb_lp),
        .usb_act_i(usb_act), .main_keep_i(main_keep),
        .wake_en_i(wake_en), .rst_en_i(rst_en),
        .sync_wr_i(sync_wr), .sync_busy_o(busy),
        .slow_core_lp_o(s_core), .slow_io_lp_o(s_io), .slow_usb_lp_o(s_usb_lp),
        .slow_usb_act_o(s_usb_act), .slow_main_keep_o(s_keep),
        .slow_wake_en_o(s_wake), .slow_rst_en_o(s_rst)
    );

    always #5 clk_fast = ~clk_fast;
    always #18.5 clk_slow = ~clk_slow;

    function automatic logic [VW-1:0] inputs_vec();
        return {rst_en, wake_en, main_keep, usb_act, usb_lp, io_lp, core_lp};
    endfunction

    function automatic logic [VW-1:0] outputs_vec();
        return {s_rst, s_wake, s_keep, s_usb_act, s_usb_lp, s_io, s_core};
    endfunction

    // Expected outputs: USB low-power enable is gated by keep-on (R5).
    function automatic logic [VW-1:0] expect_of(logic [VW-1:0] v);
        logic [VW-1:0] e = v;
        e[2] = v[2] & v[4];
        return e;
    endfunction

    task automatic check(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the model, sampled mid-cycle.
    always @(posedge clk_fast) begin
        cyc++;
        #2;
        if (rst_fast_n && rst_slow_n) begin
            if (model_pending && !busy) begin
                committed = pend_q.pop_front();
                model_pending = 0;
            end
            if (!model_pending) begin
                check(outputs_vec() == expect_of(committed), "R2/R4 idle compare",
                      outputs_vec(), expect_of(committed));
            end else begin
                check(outputs_vec() == expect_of(committed) ||
                      outputs_vec() == expect_of(pend_q[0]), "R2 in-flight compare",
                      outputs_vec(), expect_of(pend_q[0]));
            end
        end
    end

    // Pulse the trigger for one fast cycle; the model accepts it only when idle.
    task automatic trigger(bit expect_accept);
        @(negedge clk_fast);
        sync_wr = 1'b1;
        if (!model_pending) begin
            pend_q.push_back(inputs_vec());
            model_pending = 1;
        end
        @(negedge clk_fast);
        sync_wr = 1'b0;
        if (expect_accept)
            check(busy == 1'b1, "R3 busy after trigger", {{(VW-1){1'b0}}, busy}, 1);
    endtask

    task automatic wait_done();
        int n = 0;
        while (busy && n < 200) begin
            @(negedge clk_fast);
            n++;
        end
        check(n <= 64, "R4 completion latency", n, 64);
        @(negedge clk_fast);
    endtask

    task automatic set_in(logic [VW-1:0] v);
        {rst_en, wake_en, main_keep, usb_act, usb_lp, io_lp, core_lp} = v;
    endtask

    initial begin
        committed = {{(NW+NR){1'b0}}, 5'b11000};
        repeat (3) @(negedge clk_fast);
        rst_fast_n = 1'b1;
        @(negedge clk_slow);
        rst_slow_n = 1'b1;
        repeat (2) @(negedge clk_fast);

        // R1: reset state.
        check(busy == 1'b0, "R1 busy reset", {{(VW-1){1'b0}}, busy}, 0);
        check(outputs_vec() == {{(NW+NR){1'b0}}, 5'b11000}, "R1 slow reset",
              outputs_vec(), {{(NW+NR){1'b0}}, 5'b11000});

        // R2: change inputs without a trigger; slow side must not follow.
        @(negedge clk_fast);
        set_in({2'b11, 6'b111111, 5'b01111});
        repeat (40) @(negedge clk_fast);
        check(outputs_vec() == expect_of(committed), "R2 no trigger no change",
              outputs_vec(), expect_of(committed));

        // R4: transfer all-ones pattern.
        set_in({2'b11, 6'b111111, 5'b11111});
        trigger(1);
        wait_done();
        check(outputs_vec() == expect_of({2'b11, 6'b111111, 5'b11111}), "R4 all ones",
              outputs_vec(), expect_of({2'b11, 6'b111111, 5'b11111}));

        // R5: keep-on cleared with USB low-power requested.
        set_in({2'b01, 6'b101010, 5'b00111});
        trigger(1);
        wait_done();
        check(s_usb_lp == 1'b0, "R5 usb gated", {{(VW-1){1'b0}}, s_usb_lp}, 0);
        check(outputs_vec() == expect_of({2'b01, 6'b101010, 5'b00111}), "R4 alternating",
              outputs_vec(), expect_of({2'b01, 6'b101010, 5'b00111}));

        // R6 and R7: change inputs and retrigger while busy.
        set_in({2'b10, 6'b000001, 5'b10100});
        trigger(1);
        set_in({2'b01, 6'b110011, 5'b01011});
        trigger(0);
        wait_done();
        check(outputs_vec() == expect_of({2'b10, 6'b000001, 5'b10100}), "R6 snapshot kept",
              outputs_vec(), expect_of({2'b10, 6'b000001, 5'b10100}));
        for (int i = 0; i < 30; i++) begin
            @(negedge clk_fast);
            check(busy == 1'b0, "R7 no second transfer", {{(VW-1){1'b0}}, busy}, 0);
        end
        check(outputs_vec() == expect_of({2'b10, 6'b000001, 5'b10100}), "R7 values unchanged",
              outputs_vec(), expect_of({2'b10, 6'b000001, 5'b10100}));

        // R8: back-to-back transfers each complete.
        for (int k = 0; k < 4; k++) begin
            set_in(VW'(13'h0A5 << k) ^ VW'(k * 37));
            trigger(1);
            wait_done();
        end
        check(outputs_vec() == expect_of(committed), "R8 repeated transfers",
              outputs_vec(), expect_of(committed));

        repeat (5) @(negedge clk_fast);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule